// File: doc/BRIEF.md
# Pseudoinstruction Expansion Sequencer

This block turns one assembler macro-operation into the real 32-bit machine words that carry it out. A producer offers an operation selector, a destination register, a source register and a 32-bit immediate (or rotate amount) on a valid/ready input. The block then plays the expansion out, one word per accepted output beat, on a valid/ready output stream. A last flag marks the closing word of each expansion. An error flag marks the single word that stands in for an unknown selector.

Where a constant is involved, the block checks the immediate against the signed 16-bit range. A value in range gets the one-word form. Anything wider takes a multi-word form through register 1, which is kept as the scratch register. The input is a one-deep buffer. `in_ready` stays low from the acceptance of a macro-operation until its last word is taken, so expansions never interleave. Each output word stays on the pins until `out_ready` takes it. A word is accepted on any rising edge where `out_valid` and `out_ready` are both high. A macro-operation is accepted on any edge where `in_valid` and `in_ready` are both high, and its first word appears on the following cycle.

Top module: `pseudo_expander`

## Requirements
- R1: Selector 0 (move) emits one word, add with rd = destination, rs = 0, rt = source, shamt 0, funct 32, opcode 0. The fields from the MSB are opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0].
- R2: Selector 1 (load immediate) with an in-range value emits one word, addi (opcode 8) with rs = 0, rt = destination and the low 16 immediate bits in [15:0].
- R3: Selector 1 with an out-of-range value emits two words. The first is lui (opcode 15) with rs = 0, rt = destination and the upper 16 bits. The second is ori (opcode 13) with rs = rt = destination and the lower 16 bits.
- R4: A value counts as in range exactly when it lies in -32768..32767 as a signed 32-bit number. So 32767 and -32768 take the short form, and 32768, -32769 and 40000 take the long form.
- R5: Selector 4 (add-unsigned with an immediate) with an in-range value emits one addiu (opcode 9) with rs = source, rt = destination and the low 16 bits.
- R6: Selector 4 with an out-of-range value emits three words in this order: lui into register 1 with the upper half, then ori with rs = rt = 1 and the lower half, then addu (opcode 0, funct 33) with rd = destination, rs = source, rt = 1.
- R7: Selector 2 (rotate right) with amount n = imm mod 32 not zero emits three words in this order. First srl (funct 2): rd = 1, rt = source, shamt n. Then sll (funct 0): rd = destination, rt = source, shamt 32-n. Then or (funct 37): rd = destination, rs = destination, rt = 1. rs is 0 in both shifts.
- R8: Selector 2 uses only the low five immediate bits. An amount that is 0 mod 32 emits the single add of R1.
- R9: Selector 3 (no-operation) emits one all-zero word.
- R10: Selectors 5, 6 and 7 emit one all-zero word with `out_err` high. `out_err` is low on every word of a supported selector.
- R11: `out_last` is high on the final word of each expansion and low on every earlier word.
- R12: `in_ready` is low while any word of an expansion is pending. While `out_ready` is low, `out_valid`, `out_word`, `out_last` and `out_err` hold their values.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Macro-operation offered |
| in_ready | output | 1 | Block can take a macro-operation |
| in_op | input | 3 | Operation selector |
| in_dst | input | 5 | Destination register number |
| in_src | input | 5 | Source register number |
| in_imm | input | 32 | Immediate value or rotate amount |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Machine instruction word |
| out_last | output | 1 | Final word of the expansion |
| out_err | output | 1 | Word stands in for an unknown selector |

## Verification
The assertions assume the consumer follows the valid/ready protocol. They also assume that reset is held for at least one clock edge before traffic starts. No assumption is made about `in_op`: every selector value, including the unsupported ones, is legal input. The stimulus raises `in_valid` only when `in_ready` is high. It drops `in_valid` right after acceptance, and it changes `out_ready` only between clock edges. A stall is inserted before every word of alternate expansions, so both the held-word case and the back-to-back case are exercised.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int WORD_W  = 32;
  localparam int REG_W   = 5;
  localparam int OP_W    = 3;
  localparam int IMM_W   = 16;
  localparam int MAX_SEQ = 3;
  localparam int CNT_W   = $clog2(MAX_SEQ + 1);

  // selector codes
  localparam logic [OP_W-1:0] SEL_MOVE  = 3'd0;
  localparam logic [OP_W-1:0] SEL_LI    = 3'd1;
  localparam logic [OP_W-1:0] SEL_ROR   = 3'd2;
  localparam logic [OP_W-1:0] SEL_NOP   = 3'd3;
  localparam logic [OP_W-1:0] SEL_ADDUI = 3'd4;

  // major opcodes
  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_ADDI  = 6'd8;
  localparam logic [5:0] OPC_ADDIU = 6'd9;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_LUI   = 6'd15;

  // function codes
  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_OR   = 6'd37;

  localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
  localparam logic [REG_W-1:0] REG_TMP  = 5'd1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [REG_W-1:0]  reg_t;

  function automatic word_t enc_r(input reg_t rs, input reg_t rt, input reg_t rd,
                                  input logic [4:0] sh, input logic [5:0] fn);
    return {OPC_RTYPE, rs, rt, rd, sh, fn};
  endfunction

  function automatic word_t enc_i(input logic [5:0] opc, input reg_t rs, input reg_t rt,
                                  input logic [IMM_W-1:0] k);
    return {opc, rs, rt, k};
  endfunction
endpackage

// File: rtl/pex_range.sv
module pex_range #(
  parameter int VAL_W = 32,
  parameter int NARROW_W = 16
) (
  input  logic [VAL_W-1:0] value,
  output logic             fits
);
  localparam int TOP_W = VAL_W - NARROW_W + 1;
  logic [TOP_W-1:0] top;
  assign top  = value[VAL_W-1:NARROW_W-1];
  // sign-extension of the narrow field reproduces the whole value
  assign fits = (&top) | ~(|top);
endmodule

// File: rtl/pex_plan.sv
module pex_plan
  import pex_pkg::*;
(
  input  logic [OP_W-1:0]           op,
  input  reg_t                      dst,
  input  reg_t                      src,
  input  logic [WORD_W-1:0]         imm,
  output logic [MAX_SEQ-1:0][WORD_W-1:0] words,
  output logic [CNT_W-1:0]          len,
  output logic                      err
);
  logic             short_ok;
  logic [IMM_W-1:0] hi_half, lo_half;
  logic [4:0]       amt, amt_rev;

  pex_range #(.VAL_W(WORD_W), .NARROW_W(IMM_W)) u_range (
    .value(imm),
    .fits (short_ok)
  );

  assign hi_half = imm[WORD_W-1:WORD_W-IMM_W];
  assign lo_half = imm[IMM_W-1:0];
  assign amt     = imm[4:0];
  assign amt_rev = 5'd0 - amt;   // 32 - n for n in 1..31

  always_comb begin
    words = '0;
    len   = CNT_W'(1);
    err   = 1'b0;
    unique case (op)
      SEL_MOVE: begin
        words[0] = enc_r(REG_ZERO, src, dst, 5'd0, FN_ADD);
      end
      SEL_LI: begin
        if (short_ok) begin
          words[0] = enc_i(OPC_ADDI, REG_ZERO, dst, lo_half);
        end else begin
          words[0] = enc_i(OPC_LUI, REG_ZERO, dst, hi_half);
          words[1] = enc_i(OPC_ORI, dst, dst, lo_half);
          len      = CNT_W'(2);
        end
      end
      SEL_ROR: begin
        if (amt == 5'd0) begin
          words[0] = enc_r(REG_ZERO, src, dst, 5'd0, FN_ADD);
        end else begin
          words[0] = enc_r(REG_ZERO, src, REG_TMP, amt, FN_SRL);
          words[1] = enc_r(REG_ZERO, src, dst, amt_rev, FN_SLL);
          words[2] = enc_r(dst, REG_TMP, dst, 5'd0, FN_OR);
          len      = CNT_W'(3);
        end
      end
      SEL_NOP: begin
        words[0] = '0;
      end
      SEL_ADDUI: begin
        if (short_ok) begin
          words[0] = enc_i(OPC_ADDIU, src, dst, lo_half);
        end else begin
          words[0] = enc_i(OPC_LUI, REG_ZERO, REG_TMP, hi_half);
          words[1] = enc_i(OPC_ORI, REG_TMP, REG_TMP, lo_half);
          words[2] = enc_r(src, REG_TMP, dst, 5'd0, FN_ADDU);
          len      = CNT_W'(3);
        end
      end
      default: begin
        words[0] = '0;
        err      = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pex_emit.sv
module pex_emit #(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic [DEPTH-1:0][DATA_W-1:0] load_words,
  input  logic [$clog2(DEPTH+1)-1:0]  load_len,
  input  logic                        load_err,
  output logic                        busy,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DATA_W-1:0]           out_word,
  output logic                        out_last,
  output logic                        out_err
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][DATA_W-1:0] slots;
  logic [LW-1:0]                idx, len_q;
  logic                         err_q, fire, at_end;

  assign at_end = (idx == len_q - LW'(1));
  assign fire   = busy & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      len_q <= '0;
      err_q <= 1'b0;
      slots <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      idx   <= '0;
      len_q <= load_len;
      err_q <= load_err;
      slots <= load_words;
    end else if (fire) begin
      if (at_end) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + LW'(1);
      end
    end
  end

  always_comb begin
    out_word = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (idx == LW'(k)) out_word = slots[k];
    end
  end

  assign out_valid = busy;
  assign out_last  = busy & at_end;
  assign out_err   = busy & err_q;
endmodule

// File: rtl/pseudo_expander.sv
module pseudo_expander
  import pex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [REG_W-1:0]  in_dst,
  input  logic [REG_W-1:0]  in_src,
  input  logic [WORD_W-1:0] in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic              out_err
);
  logic [MAX_SEQ-1:0][WORD_W-1:0] plan_words;
  logic [CNT_W-1:0]               plan_len;
  logic                           plan_err, busy, take;

  pex_plan u_plan (
    .op   (in_op),
    .dst  (in_dst),
    .src  (in_src),
    .imm  (in_imm),
    .words(plan_words),
    .len  (plan_len),
    .err  (plan_err)
  );

  assign in_ready = ~busy;
  assign take     = in_valid & ~busy;

  pex_emit #(.DEPTH(MAX_SEQ), .DATA_W(WORD_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .load_words(plan_words),
    .load_len  (plan_len),
    .load_err  (plan_err),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_last  (out_last),
    .out_err   (out_err)
  );
endmodule

// File: rtl/pex_checker.sv
module pex_checker
  import pex_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic [REG_W-1:0]  in_dst,
  input logic [REG_W-1:0]  in_src,
  input logic [WORD_W-1:0] in_imm,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_last,
  input logic              out_err
);
  // R12: no new macro-operation while words are pending
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R12: a stalled word and its flags are held
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last) && $stable(out_err));

  // R10: error word is a single zero word
  a_r10_err_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_last && out_word == '0);

  // R11: taking the last word ends the expansion
  a_r11_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  // R11: an accepted input always yields a word next cycle
  a_r11_starts: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R13: idle flags after reset
  a_r13_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready);
endmodule

bind pseudo_expander pex_checker u_chk (.*);

// File: tb/pseudo_expander_test.sv
`timescale 1ns/1ps
module pseudo_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [4:0]  in_dst = '0;
  logic [4:0]  in_src = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        out_last;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pseudo_expander uut (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint rw(int rs, int rt, int rd, int sh, int fn);
    return longint'(rs) * 2097152 + longint'(rt) * 65536 + longint'(rd) * 2048
         + longint'(sh) * 64 + longint'(fn);
  endfunction

  function automatic longint iw(int opc, int rs, int rt, longint k);
    return longint'(opc) * 67108864 + longint'(rs) * 2097152 + longint'(rt) * 65536 + k;
  endfunction

  task automatic run_op(input int op, input int d, input int s, input logic [31:0] imm, input bit bp);
    longint exp[3];
    int     n = 1;
    bit     eerr = 0;
    string  tag;
    longint sv = longint'($signed(imm));
    bit     fit = (sv >= -32768) && (sv <= 32767);
    longint hi = longint'(imm) / 65536;
    longint lo = longint'(imm) % 65536;
    int     amt = int'(longint'(imm) % 32);
    bit     edge_val = (sv == 32767 || sv == 32768 || sv == -32768 || sv == -32769);
    exp[0] = 0; exp[1] = 0; exp[2] = 0;
    case (op)
      0: begin exp[0] = rw(0, s, d, 0, 32); tag = "R1"; end
      1: begin
        if (fit) begin exp[0] = iw(8, 0, d, lo); tag = "R2"; end
        else begin exp[0] = iw(15, 0, d, hi); exp[1] = iw(13, d, d, lo); n = 2; tag = "R3"; end
        if (edge_val) tag = "R4";
      end
      2: begin
        if (amt == 0) begin exp[0] = rw(0, s, d, 0, 32); tag = "R8"; end
        else begin
          exp[0] = rw(0, s, 1, amt, 2);
          exp[1] = rw(0, s, d, 32 - amt, 0);
          exp[2] = rw(d, 1, d, 0, 37);
          n = 3;
          tag = (imm > 31) ? "R8" : "R7";
        end
      end
      3: begin tag = "R9"; end
      4: begin
        if (fit) begin exp[0] = iw(9, s, d, lo); tag = "R5"; end
        else begin
          exp[0] = iw(15, 0, 1, hi); exp[1] = iw(13, 1, 1, lo);
          exp[2] = rw(s, 1, d, 0, 33); n = 3; tag = "R6";
        end
        if (edge_val) tag = "R4";
      end
      default: begin eerr = 1; tag = "R10"; end
    endcase

    @(negedge clk);
    check(in_ready == 1'b1, "R12 idle ready", in_ready, 1);
    in_valid = 1'b1; in_op = 3'(op); in_dst = 5'(d); in_src = 5'(s); in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0; in_imm = 32'hDEAD_BEEF;
    for (int i = 0; i < n; i++) begin
      if (bp) begin
        logic [31:0] held;
        out_ready = 1'b0;
        held = out_word;
        @(negedge clk);
        check(out_valid && out_word == held, "R12 stall hold", out_word, held);
      end
      out_ready = 1'b1;
      check(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
      check(out_word == exp[i][31:0], {tag, " word"}, out_word, exp[i] & 32'hFFFF_FFFF);
      check(out_last == (i == n - 1), "R11 last", out_last, (i == n - 1));
      check(out_err == eerr, "R10 err", out_err, eerr);
      check(in_ready == 1'b0, "R12 busy ready", in_ready, 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, {tag, " length"}, out_valid, 0);
  endtask

  initial begin
    logic [31:0] vals[10];
    int pairs_d[3];
    int pairs_s[3];
    int txn = 0;
    vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd32767, 32'd32768, 32'hFFFF_8000,
             32'hFFFF_7FFF, 32'd40000, 32'h1234_5678, 32'hFFFF_0000};
    pairs_d = '{2, 31, 9};
    pairs_s = '{7, 1, 9};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R13 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R13 valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R13 ready after reset", in_ready, 1);
    for (int op = 0; op < 8; op++)
      for (int p = 0; p < 3; p++)
        for (int v = 0; v < 10; v++) begin
          run_op(op, pairs_d[p], pairs_s[p], vals[v], txn[0]);
          txn++;
        end
    for (int a = 0; a < 70; a++) begin
      run_op(2, 4, 12, 32'(a), a[0]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule